// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Execution Unit

This unit decodes and executes one signed halfword multiply instruction word per cycle for a 32-bit RISC datapath. It recognises four operation families: a 16x16 signed multiply, a 16x16 signed multiply with a 32-bit addend, a 32x16 signed multiply that keeps the upper 32 bits of the 48-bit product, and the same wide multiply with a 32-bit addend. The register file has already supplied three 32-bit operands, `op_a`, `op_b` and `op_acc`, next to the instruction word and a valid strobe.

The arithmetic is a single combinational path: halfword selection, sign extension, the multiply, the 16-bit arithmetic shift for the wide forms and the final addition. Its result is captured in one output register. A word that has the fixed bit pattern of this group but an unknown opcode raises a one-cycle illegal flag and produces no result. A signed overflow in any accumulating form sets a sticky flag, which is cleared only by a dedicated clear input.

Top module: `hw_mac_unit`

## Requirements
- R1: A word belongs to the group only when bit 4 is 0, bit 7 is 1 and bit 20 is 0. A strobed word without that pattern raises neither `res_valid` nor `illegal_op` in the next cycle, leaves `result` unchanged and never sets the overflow flag.
- R2: Opcode field bits 27:21 = 7'b0001011 is the 16x16 multiply. Bit 5 picks the half of `op_a` and bit 6 picks the half of `op_b` (0 = bits 15:0 sign-extended, 1 = bits 31:16, the arithmetic shift right by 16). The result is the signed 32-bit product.
- R3: Opcode 7'b0001000 is the 16x16 multiply-accumulate. It uses the same half selection as R2 and adds `op_acc` to the product.
- R4: Opcode 7'b0001001 with bit 5 = 1 is the wide multiply. The result is bits 47:16 of the exact 48-bit signed product of all of `op_a` and the half of `op_b` picked by bit 6 (0 = bottom, 1 = top). For 0x80000000 times 0x8000 it gives 0x40000000.
- R5: Opcode 7'b0001001 with bit 5 = 0 is the wide multiply-accumulate: `op_acc` plus the shifted wide product of R4.
- R6: A non-accumulating form never sets the overflow flag. The 16x16 product 0x8000 by 0x8000 gives 0x40000000.
- R7: In an accumulating form, a final sum outside the signed 32-bit range sets `ovf_flag` and the result wraps modulo 2^32. The flag stays set over later operations that do not overflow.
- R8: `ovf_clear` high at a clock edge clears `ovf_flag`. If an accumulating overflow is captured at the same edge, the flag ends set.
- R9: A strobed word with the fixed pattern but any other opcode raises `illegal_op` for exactly one cycle. In that cycle `res_valid` is low and `result` keeps its previous value.
- R10: `result` and `res_valid` update at the rising edge after the strobe. `result` holds whenever no result is produced. A synchronous active-high `rst` clears `res_valid`, `illegal_op`, `ovf_flag` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand (a half is selected) |
| op_acc | input | 32 | Addend for the accumulating forms |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| result | output | 32 | Registered result |
| res_valid | output | 1 | `result` was produced at the last edge |
| illegal_op | output | 1 | The last strobed word had an unknown opcode |
| ovf_flag | output | 1 | Sticky signed accumulate overflow |

## Verification
The bench targets the most negative operands. A 16x16 product of 0x8000 by 0x8000 exposes a design that sizes the product at 16 bits or flags overflow on a plain multiply. A 0x80000000 by -32768 wide product exposes a design that shifts at 32 bits and loses the upper bits. It swaps the opcodes and the mode bit 5 of the wide forms, because a design with the multiply and accumulate senses swapped adds a stray addend. It drives accumulator edges at 0x7FFFFFFF and 0x80000000 to check wrap and the sticky flag. It also sets a clear and an overflow at the same edge, where a wrong priority drops the flag. It drives near-miss words with one fixed bit wrong and unknown opcodes, where a loose decoder would produce a result or overwrite the held value.

// File: rtl/hw_mac_unit.sv
module hw_mac_unit #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [XW-1:0] op_a,
  input  logic [XW-1:0] op_b,
  input  logic [XW-1:0] op_acc,
  input  logic          ovf_clear,
  output logic [XW-1:0] result,
  output logic          res_valid,
  output logic          illegal_op,
  output logic          ovf_flag
);
  localparam int HW = XW / 2;
  localparam int PW = XW + HW;
  localparam logic [6:0] OPC_MUL16 = 7'b0001011;
  localparam logic [6:0] OPC_MAC16 = 7'b0001000;
  localparam logic [6:0] OPC_WIDE  = 7'b0001001;

  // decode
  logic [6:0] opc;
  logic fixed_ok, is_mul16, is_mac16, is_wide, known, fire, bad, acc_en;
  assign opc      = instr[27:21];
  assign fixed_ok = ~instr[4] & instr[7] & ~instr[20];
  assign is_mul16 = (opc == OPC_MUL16);
  assign is_mac16 = (opc == OPC_MAC16);
  assign is_wide  = (opc == OPC_WIDE);
  assign known    = is_mul16 | is_mac16 | is_wide;
  assign fire     = in_valid & fixed_ok & known;
  assign bad      = in_valid & fixed_ok & ~known;
  assign acc_en   = is_mac16 | (is_wide & ~instr[5]);

  // operand halves
  logic [HW-1:0] a_half, b_half;
  assign a_half = instr[5] ? op_a[XW-1:HW] : op_a[HW-1:0];
  assign b_half = instr[6] ? op_b[XW-1:HW] : op_b[HW-1:0];

  // products
  logic signed [XW-1:0] prod_hh;
  logic signed [PW-1:0] prod_wh;
  assign prod_hh = $signed(a_half) * $signed(b_half);
  assign prod_wh = $signed(op_a) * $signed(b_half);

  // accumulate
  logic [XW-1:0] base, addend, sum;
  logic add_ovf;
  assign base    = is_wide ? prod_wh[PW-1:HW] : prod_hh;
  assign addend  = acc_en ? op_acc : '0;
  assign sum     = base + addend;
  assign add_ovf = acc_en & (base[XW-1] == op_acc[XW-1]) & (sum[XW-1] != base[XW-1]);

  logic unused_bits;
  assign unused_bits = ^{instr[31:28], instr[19:8], instr[3:0], prod_wh[HW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      res_valid  <= 1'b0;
      illegal_op <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      res_valid  <= fire;
      illegal_op <= bad;
      ovf_flag   <= (ovf_flag & ~ovf_clear) | (fire & add_ovf);
      if (fire) result <= sum;
    end
  end

  // R9: a word is either executed or flagged, never both
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && illegal_op));

  // R10: a result only follows a strobe
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && !illegal_op);

  // R10: result holds when nothing executes
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(result));

  // R1: words outside the group are not decoded
  a_r1_nodecode: assert property (@(posedge clk) disable iff (rst)
    in_valid && !fixed_ok |=> !res_valid && !illegal_op);

  // R7: flag is sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !ovf_clear |=> ovf_flag);

  // R6: only an accumulating execution can raise the flag
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !ovf_flag && !(fire && acc_en) |=> !ovf_flag);
endmodule

// File: tb/hw_mac_unit_tb_top.sv
module hw_mac_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0, op_a = '0, op_b = '0, op_acc = '0;
  logic ovf_clear = 1'b0;
  logic [31:0] result;
  logic res_valid, illegal_op, ovf_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  hw_mac_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .op_a(op_a), .op_b(op_b), .op_acc(op_acc), .ovf_clear(ovf_clear),
    .result(result), .res_valid(res_valid), .illegal_op(illegal_op),
    .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic        v;
    logic        ill;
    logic        ovf;
    logic [31:0] res;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [31:0] m_res = '0;
  logic        m_ovf = 1'b0;
  bit          done  = 1'b0;

  localparam logic [6:0] K_MUL = 7'b0001011;
  localparam logic [6:0] K_MAC = 7'b0001000;
  localparam logic [6:0] K_WID = 7'b0001001;

  function automatic logic [31:0] enc(input logic [6:0] op, input logic x, input logic y);
    return {4'hE, op, 1'b0, 12'h5A3, 1'b1, y, x, 1'b0, 4'h7};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic v, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic clr);
    exp_t e;
    logic fx, kn, acc, ov;
    longint ha, hb, base, s;
    @(negedge clk);
    in_valid = v; instr = w; op_a = a; op_b = b; op_acc = c; ovf_clear = clr;
    fx  = (w[4] == 1'b0) && (w[7] == 1'b1) && (w[20] == 1'b0);
    kn  = (w[27:21] == K_MUL) || (w[27:21] == K_MAC) || (w[27:21] == K_WID);
    acc = (w[27:21] == K_MAC) || ((w[27:21] == K_WID) && !w[5]);
    ha  = w[5] ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
    hb  = w[6] ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    if (w[27:21] == K_WID) base = (longint'($signed(a)) * hb) >>> 16;
    else base = ha * hb;
    s  = base + (acc ? longint'($signed(c)) : 64'sd0);
    ov = acc && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
    e.v   = v && fx && kn;
    e.ill = v && fx && !kn;
    if (e.v) m_res = s[31:0];
    m_ovf = (m_ovf && !clr) || (e.v && ov);
    e.res = m_res;
    e.ovf = m_ovf;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    issue(tag, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.tag, "res_valid", {31'd0, res_valid}, {31'd0, e.v});
        chk(e.tag, "illegal_op", {31'd0, illegal_op}, {31'd0, e.ill});
        chk(e.tag, "ovf_flag", {31'd0, ovf_flag}, {31'd0, e.ovf});
        chk(e.tag, "result", result, e.res);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", "reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R10", "reset illegal_op", {31'd0, illegal_op}, 32'd0);
    chk("R10", "reset ovf_flag", {31'd0, ovf_flag}, 32'd0);
    chk("R10", "reset result", result, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2 all half combinations
    for (int k = 0; k < 4; k++)
      issue("R2", 1'b1, enc(K_MUL, k[0], k[1]), 32'hFFFE_0003, 32'h0007_FFFB, 32'h1234_5678, 1'b0);
    // R6 most negative halves
    issue("R6", 1'b1, enc(K_MUL, 1'b0, 1'b0), 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 1'b0);
    issue("R6", 1'b1, enc(K_MUL, 1'b1, 1'b1), 32'h8000_0000, 32'h8000_1234, 32'h0, 1'b0);
    // R3 multiply-accumulate combos
    for (int k = 0; k < 4; k++)
      issue("R3", 1'b1, enc(K_MAC, k[0], k[1]), 32'h8001_7FFF, 32'hC000_0101, 32'hFFFF_FF00, 1'b0);
    // R4 wide multiply
    issue("R4", 1'b1, enc(K_WID, 1'b1, 1'b0), 32'h1234_5678, 32'h0000_ABCD, 32'h7FFF_FFFF, 1'b0);
    issue("R4", 1'b1, enc(K_WID, 1'b1, 1'b1), 32'hDEAD_BEEF, 32'h7FFF_0000, 32'h0, 1'b0);
    issue("R4", 1'b1, enc(K_WID, 1'b1, 1'b1), 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0);
    issue("R4", 1'b1, enc(K_WID, 1'b1, 1'b0), 32'h8000_0000, 32'h0000_8000, 32'h0, 1'b0);
    // R5 wide multiply-accumulate
    issue("R5", 1'b1, enc(K_WID, 1'b0, 1'b0), 32'h1234_5678, 32'h0000_ABCD, 32'h0000_1000, 1'b0);
    issue("R5", 1'b1, enc(K_WID, 1'b0, 1'b1), 32'hFFFF_0000, 32'h0003_0000, 32'h8000_0000, 1'b0);
    idle("R10");
    // R7 overflow and wrap
    issue("R7", 1'b1, enc(K_MAC, 1'b0, 1'b0), 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0);
    issue("R7", 1'b1, enc(K_MUL, 1'b0, 1'b0), 32'h0000_0003, 32'h0000_0005, 32'h0, 1'b0);
    issue("R7", 1'b1, enc(K_MAC, 1'b0, 1'b0), 32'h0000_0002, 32'h0000_0002, 32'h0000_0010, 1'b0);
    // R8 clear, then clear together with overflow
    issue("R8", 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    idle("R8");
    issue("R8", 1'b1, enc(K_WID, 1'b0, 1'b0), 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 1'b1);
    issue("R8", 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    // R7 negative accumulate overflow
    issue("R7", 1'b1, enc(K_MAC, 1'b1, 1'b0), 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b0);
    issue("R8", 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    // R9 unknown opcodes with the fixed pattern
    issue("R9", 1'b1, enc(K_MUL, 1'b0, 1'b0), 32'h0000_0011, 32'h0000_0022, 32'h0, 1'b0);
    issue("R9", 1'b1, enc(7'b0001010, 1'b0, 1'b0), 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 1'b0);
    issue("R9", 1'b1, enc(7'b1001011, 1'b1, 1'b1), 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 1'b0);
    idle("R9");
    // R1 near-miss words
    issue("R1", 1'b1, enc(K_MAC, 1'b0, 1'b0) | 32'h0000_0010, 32'h7FFF_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0);
    issue("R1", 1'b1, enc(K_MAC, 1'b0, 1'b0) & ~32'h0000_0080, 32'h7FFF_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0);
    issue("R1", 1'b1, enc(7'b0001010, 1'b0, 1'b0) | 32'h0010_0000, 32'h7FFF_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0);
    // R10 valid low with a legal word
    issue("R10", 1'b0, enc(K_MUL, 1'b0, 1'b0), 32'h0000_0005, 32'h0000_0005, 32'h0, 1'b0);
    // back-to-back mix
    issue("R2", 1'b1, enc(K_MUL, 1'b1, 1'b0), 32'h8000_FFFF, 32'h0000_8000, 32'h0, 1'b0);
    issue("R5", 1'b1, enc(K_WID, 1'b0, 1'b1), 32'h7FFF_FFFF, 32'h7FFF_0000, 32'h7FFF_FFFF, 1'b0);
    idle("R10");
    idle("R10");
    while (sb.size() > 0) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule